// File: doc/BRIEF.md
# Byte and Halfword Insert/Extract Execution Unit

This block executes four 16-bit register-to-register instructions of a 32-bit register machine in a single cycle. Two of them insert the low byte or the low halfword of a source register into one field of a destination register. The other two copy one byte or halfword of a source register into the low end of a destination register and fill the upper bits with zeros. The field is chosen at run time by the low bits of a third register, the index register. Typical use is packing and unpacking sub-word data around whole-word memory accesses.

The unit holds a sixteen-entry register file, the instruction decoder, the lane-select datapath and a four-bit condition-code register with flags N, Z, V and C. Register 0 always reads as zero. A write to register 0 is discarded. A debug port can write any register and read any register back, so that the unit can be set up and observed.

Top module: `bfx_unit`

## Requirements
- R1: Instruction fields are s1 = instr[15:12], x = instr[11:8], op = instr[7:4] and dst = instr[3:0]. The opcodes are 0111 insert byte, 0110 insert halfword, 0101 extract byte and 0100 extract halfword. An instruction is taken on a rising edge while instr_valid is high.
- R2: Insert byte writes src[7:0] into bits b+7..b of r[dst], where b = (r[x] & 3) * 8. All other bits of r[dst] keep their values.
- R3: Insert halfword writes src[15:0] into bits h+15..h of r[dst], where h = (r[x] & 2) * 8, so bit 0 of the index has no effect. All other bits of r[dst] keep their values.
- R4: Insert instructions leave flags (flags[3]=N, flags[2]=Z, flags[1]=V, flags[0]=C) unchanged.
- R5: Extract byte writes {24'b0, r[s1][b+7:b]} to r[dst].
- R6: Extract halfword writes {16'b0, r[s1][h+15:h]} to r[dst].
- R7: After an extract, Z is 1 exactly when the extracted value is zero, and N, V and C are 0. The flags are visible in the cycle after the instruction edge.
- R8: An s1 or x operand that names register 0 supplies the value zero. With x = 0 the lowest byte or halfword is selected.
- R9: An extract with dst = 0 changes no register but still updates the flags as in R7.
- R10: An insert with dst = 0 changes no register and no flag. It raises illegal_o for exactly the one cycle after the instruction edge.
- R11: Any opcode other than the four in R1 changes no register and no flag. It raises unsupported_o for exactly the one cycle after the instruction edge.
- R12: After reset, flags, illegal_o, unsupported_o and dbg_rdata are all 0. Both pulse outputs stay low in any cycle that follows an edge with no valid instruction.
- R13: A debug write stores dbg_wdata in register dbg_waddr on the edge, except that register 0 stays zero. dbg_rdata shows register dbg_raddr as it was at the previous edge. If a debug write and an instruction write land on the same edge, the debug write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| dbg_we | input | 1 | Debug register write enable |
| dbg_waddr | input | 4 | Debug write register number |
| dbg_wdata | input | 32 | Debug write data |
| dbg_raddr | input | 4 | Debug read register number |
| dbg_rdata | output | 32 | Registered debug read data |
| flags | output | 4 | Condition codes {N,Z,V,C} |
| illegal_o | output | 1 | Pulse: insert aimed at register 0 |
| unsupported_o | output | 1 | Pulse: opcode outside the supported four |

## Verification
All four instructions are run with every index value from 0 to 3. The index register carries unrelated high bits, which shows that only its low bits choose the field. Three source patterns are used: one with distinct bytes everywhere, so that a wrong lane shows up; one whose only nonzero byte sits in the upper half, so that Z separates the extracted fields; and one with scattered single bits, so that a misplaced field boundary shows up. Register-0 operands are tried as source, as index and as destination, alongside an unsupported opcode, which together cover the zero-source, discard and signalling paths.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned FIELD_W = 4;

  typedef enum logic [3:0] {
    OP_EXT_HALF   = 4'b0100,
    OP_EXT_BYTE   = 4'b0101,
    OP_INS_HALF   = 4'b0110,
    OP_INS_BYTE   = 4'b0111
  } bfx_op_e;

  typedef struct packed {
    logic legal;     // one of the four supported opcodes
    logic insert;    // insert (1) or extract (0)
    logic byte_mode; // byte (1) or halfword (0)
  } bfx_ctl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } bfx_flags_t;
endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
  import bfx_pkg::*;
(
  input  logic [3:0] op,
  output bfx_ctl_t   ctl
);
  always_comb begin
    ctl.legal     = (op[3:2] == 2'b01);
    ctl.insert    = op[1];
    ctl.byte_mode = op[0];
  end
endmodule

// File: rtl/bfx_regfile.sv
module bfx_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  parameter int unsigned IW   = 2,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd,
  input  logic [AW-1:0]   ra_src,
  input  logic [AW-1:0]   ra_idx,
  input  logic [AW-1:0]   ra_dst,
  output logic [XLEN-1:0] rd_src,
  output logic [IW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_dst,
  input  logic [AW-1:0]   ra_dbg,
  output logic [XLEN-1:0] rd_dbg
);
  logic [XLEN-1:0] mem [NREG];

  // Single write port with no reset, so the array maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) mem[wa] <= wd;
  end

  always_comb begin
    rd_src = (ra_src == '0) ? '0 : mem[ra_src];
    rd_idx = (ra_idx == '0) ? '0 : mem[ra_idx][IW-1:0];
    rd_dst = (ra_dst == '0) ? '0 : mem[ra_dst];
  end

  // Registered observation port; returns the contents before this edge's write
  always_ff @(posedge clk) begin
    if (rst)                 rd_dbg <= '0;
    else if (ra_dbg == '0)   rd_dbg <= '0;
    else                     rd_dbg <= mem[ra_dbg];
  end
endmodule

// File: rtl/bfx_field.sv
module bfx_field #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned NLANE = XLEN / 8,
  localparam int unsigned NHALF = NLANE / 2,
  localparam int unsigned IW    = $clog2(NLANE)
) (
  input  logic            insert,
  input  logic            byte_mode,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] dst,
  input  logic [IW-1:0]   idx,
  output logic [XLEN-1:0] result,
  output logic            field_zero
);
  logic [XLEN-1:0] ins_val;
  logic [7:0]      ext_byte;
  logic [15:0]     ext_half;
  logic [IW-2:0]   half_sel;

  assign half_sel = idx[IW-1:1];

  // Insert: each byte lane either keeps dst or takes a source byte
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic hit_b, hit_h;
    assign hit_b = (idx == IW'(g));
    assign hit_h = (half_sel == (IW-1)'(g / 2));
    always_comb begin
      if (byte_mode && hit_b)       ins_val[g*8 +: 8] = src[7:0];
      else if (!byte_mode && hit_h) ins_val[g*8 +: 8] = src[(g % 2)*8 +: 8];
      else                          ins_val[g*8 +: 8] = dst[g*8 +: 8];
    end
  end

  // Extract: select one lane or half-lane pair
  always_comb begin
    ext_byte = '0;
    ext_half = '0;
    for (int i = 0; i < NLANE; i++)
      if (idx == IW'(i)) ext_byte = src[i*8 +: 8];
    for (int j = 0; j < NHALF; j++)
      if (half_sel == (IW-1)'(j)) ext_half = src[j*16 +: 16];
  end

  always_comb begin
    if (insert) begin
      result     = ins_val;
      field_zero = 1'b0;
    end else if (byte_mode) begin
      result     = {{(XLEN-8){1'b0}}, ext_byte};
      field_zero = (ext_byte == '0);
    end else begin
      result     = {{(XLEN-16){1'b0}}, ext_half};
      field_zero = (ext_half == '0);
    end
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 16,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned IW  = $clog2(XLEN / 8)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                instr_valid,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                dbg_we,
  input  logic [AW-1:0]       dbg_waddr,
  input  logic [XLEN-1:0]     dbg_wdata,
  input  logic [AW-1:0]       dbg_raddr,
  output logic [XLEN-1:0]     dbg_rdata,
  output logic [3:0]          flags,
  output logic                illegal_o,
  output logic                unsupported_o
);
  logic [AW-1:0]   f_s1, f_x, f_dst;
  logic [3:0]      f_op;
  bfx_ctl_t        ctl;
  logic [XLEN-1:0] src_val, dst_val, res;
  logic [IW-1:0]   idx_val;
  logic            fzero;
  logic            exec_ok, bad_dst, exec_we;
  logic            rf_we;
  logic [AW-1:0]   rf_wa;
  logic [XLEN-1:0] rf_wd;
  bfx_flags_t      flg_q;

  assign f_s1  = instr[15:12];
  assign f_x   = instr[11:8];
  assign f_op  = instr[7:4];
  assign f_dst = instr[3:0];

  bfx_decode u_dec (.op(f_op), .ctl(ctl));

  bfx_regfile #(.XLEN(XLEN), .NREG(NREG), .IW(IW)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd),
    .ra_src(f_s1), .ra_idx(f_x), .ra_dst(f_dst),
    .rd_src(src_val), .rd_idx(idx_val), .rd_dst(dst_val),
    .ra_dbg(dbg_raddr), .rd_dbg(dbg_rdata)
  );

  bfx_field #(.XLEN(XLEN)) u_fld (
    .insert(ctl.insert), .byte_mode(ctl.byte_mode),
    .src(src_val), .dst(dst_val), .idx(idx_val),
    .result(res), .field_zero(fzero)
  );

  always_comb begin
    exec_ok = instr_valid && ctl.legal;
    bad_dst = exec_ok && ctl.insert && (f_dst == '0);
    exec_we = exec_ok && (f_dst != '0);
    rf_we   = dbg_we || exec_we;
    rf_wa   = dbg_we ? dbg_waddr : f_dst;
    rf_wd   = dbg_we ? dbg_wdata : res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q         <= '0;
      illegal_o     <= 1'b0;
      unsupported_o <= 1'b0;
    end else begin
      illegal_o     <= bad_dst;
      unsupported_o <= instr_valid && !ctl.legal;
      if (exec_ok && !ctl.insert) begin
        flg_q.n <= 1'b0;
        flg_q.z <= fzero;
        flg_q.v <= 1'b0;
        flg_q.c <= 1'b0;
      end
    end
  end

  assign flags = flg_q;
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       instr_valid,
  input logic [7:0] op_dst,
  input logic [3:0] flags,
  input logic       illegal_o,
  input logic       unsupported_o
);
  logic is_legal, is_ins, dst_zero;
  assign is_legal = (op_dst[7:6] == 2'b01);
  assign is_ins   = op_dst[5];
  assign dst_zero = (op_dst[3:0] == 4'd0);

  assert_ins_flags_R4: assert property (@(posedge clk) disable iff (rst)
    instr_valid && is_legal && is_ins |=> $stable(flags));

  assert_ext_nvc_R7: assert property (@(posedge clk) disable iff (rst)
    instr_valid && is_legal && !is_ins |=> (flags[3] == 1'b0) && (flags[1:0] == 2'b00));

  assert_ins_r0_illegal_R10: assert property (@(posedge clk) disable iff (rst)
    instr_valid && is_legal && is_ins && dst_zero |=> illegal_o && !unsupported_o);

  assert_unsup_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    instr_valid && !is_legal |=> unsupported_o && !illegal_o && $stable(flags));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !illegal_o && !unsupported_o && $stable(flags));

  assert_pulses_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(illegal_o && unsupported_o));
endmodule

bind bfx_unit bfx_unit_chk u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .op_dst(instr[7:0]),
  .flags(flags), .illegal_o(illegal_o), .unsupported_o(unsupported_o)
);

// File: tb/tb_bfx_unit.sv
module tb_bfx_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [15:0] instr;
  logic        dbg_we;
  logic [3:0]  dbg_waddr, dbg_raddr;
  logic [31:0] dbg_wdata, dbg_rdata;
  logic [3:0]  flags;
  logic        illegal_o, unsupported_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_flags;
  logic       s_ill, s_uns;
  logic [3:0] s_flags;

  always #10 clk = ~clk; // 50 MHz

  bfx_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .dbg_we(dbg_we), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata),
    .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata), .flags(flags),
    .illegal_o(illegal_o), .unsupported_o(unsupported_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    dbg_we = 1'b1; dbg_waddr = a; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    dbg_raddr = a;
    @(negedge clk);
    d = dbg_rdata;
  endtask

  task automatic run(input logic [3:0] s1, input logic [3:0] x,
                     input logic [3:0] op, input logic [3:0] dst);
    @(negedge clk);
    instr_valid = 1'b1; instr = {s1, x, op, dst};
    @(negedge clk);
    instr_valid = 1'b0;
    s_ill = illegal_o; s_uns = unsupported_o; s_flags = flags;
  endtask

  function automatic logic [31:0] ref_ins(input logic [31:0] d, input logic [31:0] s,
                                          input logic [1:0] i, input logic byt);
    logic [4:0]  lo;
    logic [31:0] m;
    lo = byt ? {i, 3'b000} : {i[1], 4'b0000};
    m  = byt ? 32'h0000_00FF : 32'h0000_FFFF;
    return (d & ~(m << lo)) | ((s & m) << lo);
  endfunction

  function automatic logic [31:0] ref_ext(input logic [31:0] s, input logic [1:0] i,
                                          input logic byt);
    logic [4:0] lo;
    lo = byt ? {i, 3'b000} : {i[1], 4'b0000};
    return byt ? ((s >> lo) & 32'hFF) : ((s >> lo) & 32'hFFFF);
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pats [3];
    logic [31:0] e;
    logic [31:0] dinit;
    pats[0] = 32'hA1B2_C3D4;
    pats[1] = 32'h00FF_0000;
    pats[2] = 32'h8000_0100;
    dinit   = 32'h1357_9BDF;

    rst = 1'b1; instr_valid = 1'b0; instr = '0;
    dbg_we = 1'b0; dbg_waddr = '0; dbg_wdata = '0; dbg_raddr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check("R12 flags", {28'd0, flags}, 32'd0);
    check("R12 illegal", {31'd0, illegal_o}, 32'd0);
    check("R12 unsupported", {31'd0, unsupported_o}, 32'd0);
    check("R12 dbg_rdata", dbg_rdata, 32'd0);
    exp_flags = 4'b0000;

    // R13 debug write and read back, register 0 stays zero
    wr(4'd7, 32'hCAFE_F00D);
    rd(4'd7, v); check("R13 write r7", v, 32'hCAFE_F00D);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); check("R13 r0 stays zero", v, 32'd0);

    // R1/R2/R3/R5/R6/R4/R7 sweep: all ops, all index values, three patterns
    for (int p = 0; p < 3; p++) begin
      for (int op = 4; op < 8; op++) begin
        for (int ix = 0; ix < 4; ix++) begin
          logic byt, ins;
          byt = op[0]; ins = op[1];
          wr(4'd3, pats[p]);
          wr(4'd2, 32'hABCD_EF00 | ix);
          wr(4'd4, dinit);
          run(4'd3, 4'd2, 4'(op), 4'd4);
          if (ins) begin
            e = ref_ins(dinit, pats[p], 2'(ix), byt);
          end else begin
            e = ref_ext(pats[p], 2'(ix), byt);
            exp_flags = {1'b0, (e == 0), 2'b00};
          end
          check(ins ? "R4/R7 flags after insert" : "R7 flags after extract",
                {28'd0, s_flags}, {28'd0, exp_flags});
          check("R11/R10 no pulse on legal op", {30'd0, s_ill, s_uns}, 32'd0);
          rd(4'd4, v);
          if (ins && byt)       check("R1/R2 insert byte", v, e);
          else if (ins)         check("R1/R3 insert half", v, e);
          else if (byt)         check("R1/R5 extract byte", v, e);
          else                  check("R1/R6 extract half", v, e);
        end
      end
    end

    // R8: register 0 as index picks lowest field
    wr(4'd3, 32'hA1B2_C3D4);
    run(4'd3, 4'd0, 4'b0101, 4'd5);
    rd(4'd5, v); check("R8 x=r0 extract byte", v, 32'h0000_00D4);
    exp_flags = 4'b0000;
    // R8: register 0 as source clears selected byte
    wr(4'd2, 32'd2);
    wr(4'd4, 32'hFFFF_FFFF);
    run(4'd0, 4'd2, 4'b0111, 4'd4);
    rd(4'd4, v); check("R8 s1=r0 insert byte", v, 32'hFF00_FFFF);
    // R8: both zero clears low half
    run(4'd0, 4'd0, 4'b0110, 4'd4);
    rd(4'd4, v); check("R8 s1=x=r0 insert half", v, 32'hFF00_0000);

    // R9: extract into r0 tests field, register untouched
    wr(4'd3, 32'h1234_0000);
    run(4'd3, 4'd0, 4'b0100, 4'd0);
    check("R9 flags Z set on discard", {28'd0, s_flags}, 32'h4);
    rd(4'd0, v); check("R9 r0 still zero", v, 32'd0);
    rd(4'd3, v); check("R9 source intact", v, 32'h1234_0000);
    exp_flags = 4'b0100;

    // R10: insert with dst=0
    run(4'd3, 4'd0, 4'b0110, 4'd0);
    check("R10 illegal pulse", {31'd0, s_ill}, 32'd1);
    check("R10 flags unchanged", {28'd0, s_flags}, {28'd0, exp_flags});
    @(negedge clk);
    check("R10 pulse one cycle", {31'd0, illegal_o}, 32'd0);
    rd(4'd0, v); check("R10 r0 zero", v, 32'd0);

    // R11: unsupported opcodes
    wr(4'd4, 32'h5555_AAAA);
    run(4'd3, 4'd2, 4'b0011, 4'd4);
    check("R11 unsupported pulse", {31'd0, s_uns}, 32'd1);
    check("R11 flags unchanged", {28'd0, s_flags}, {28'd0, exp_flags});
    @(negedge clk);
    check("R11 pulse one cycle", {31'd0, unsupported_o}, 32'd0);
    rd(4'd4, v); check("R11 dst unchanged", v, 32'h5555_AAAA);
    run(4'd3, 4'd2, 4'b1101, 4'd4);
    check("R11 unsupported high op", {31'd0, s_uns}, 32'd1);
    rd(4'd4, v); check("R11 dst unchanged high op", v, 32'h5555_AAAA);

    // R13: debug write wins over instruction write on the same edge
    @(negedge clk);
    instr_valid = 1'b1; instr = {4'd3, 4'd0, 4'b0101, 4'd6};
    dbg_we = 1'b1; dbg_waddr = 4'd6; dbg_wdata = 32'h0BAD_BEEF;
    @(negedge clk);
    instr_valid = 1'b0; dbg_we = 1'b0;
    rd(4'd6, v); check("R13 debug priority", v, 32'h0BAD_BEEF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule